// File: doc/BRIEF.md
# Ethernet PAUSE Flow-Control Timer

This block is the flow-control timer of a full-duplex Ethernet MAC. Software sees a single 16-bit word whose meaning depends on a mode input. When the mode input is high, the word is the pause duration, in slot times, that the frame generator places into outgoing PAUSE control frames. When the mode input is low, reading the word returns the slot times still left in the pause period that began when the receiver accepted a PAUSE frame.

The receive path presents a one-cycle strobe for each accepted PAUSE frame together with that frame's quanta value. The timer loads its countdown from that value and asserts a transmit-hold output until the countdown reaches zero. One slot time is 512 bit times, and it is measured with a prescaler driven by a bit-time tick. Each acceptance also sets an event flag. The flag drives an interrupt output when it is enabled, and software clears it with a write-one strobe. Frame parsing, CRC checking and frame generation are handled outside this block.

Top module: `pause_flow_timer`

## Requirements
- R1: One slot time is 512 bit-time ticks. The countdown drops by exactly one after each group of 512 cycles with `bit_tick` high, counted from the cycle that accepted the frame. It never changes on any other cycle unless a new frame is accepted.
- R2: While `mode_tx` is 1, `rd_value` returns the programmed pause duration. `tx_quanta` always carries that duration. A write accepted while `tx_active` is 0 becomes visible one cycle after its clock edge.
- R3: While `mode_tx` is 0, `rd_value` returns the remaining slot count. Every accepted PAUSE frame loads the countdown from `pause_quanta`, whatever the value of `mode_tx`.
- R4: A write (`wr_en` high) presented while `mode_tx` is 0 is ignored. The programmed duration keeps its previous value.
- R5: `tx_hold` is 1 exactly while the remaining slot count is nonzero. The count stops at zero and never wraps below it.
- R6: An accepted PAUSE frame with quanta 0 ends any pause in progress. `tx_hold` is 0 and the count is 0 from the next cycle.
- R7: A write that arrives with `mode_tx` 1 while `tx_active` is 1 is held back. The programmed duration does not change while `tx_active` stays 1. The held value is applied at the first clock edge at which `tx_active` is 0. A later write replaces an earlier one that is still held back.
- R8: Each accepted PAUSE frame sets `rfc_flag` from the next cycle. `irq` equals `rfc_flag` AND `irq_en`.
- R9: The flag clears when `flag_wr` is high with `flag_wr_data` 1. With `flag_wr_data` 0 the flag is unchanged. An acceptance in the same cycle as a clear leaves the flag set.
- R10: Synchronous reset clears the countdown, the prescaler, the programmed duration, any held-back write and the flag. After reset `tx_hold`, `rd_value`, `rfc_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One pulse per bit time |
| pause_acc | input | 1 | Strobe marking an accepted PAUSE frame |
| pause_quanta | input | 16 | Quanta value of the accepted frame |
| mode_tx | input | 1 | 1: word is the transmit duration; 0: word is the remaining count |
| tx_active | input | 1 | Transmitter is busy sending a frame |
| wr_en | input | 1 | Software write strobe for the word |
| wr_data | input | 16 | Software write data |
| flag_wr | input | 1 | Software write strobe for the event flag |
| flag_wr_data | input | 1 | Write-one-to-clear data bit for the event flag |
| irq_en | input | 1 | Interrupt enable for the event flag |
| tx_hold | output | 1 | Transmitter stopped by a received PAUSE frame |
| rd_value | output | 16 | Read value of the word |
| tx_quanta | output | 16 | Programmed duration for outgoing PAUSE frames |
| rfc_flag | output | 1 | Receive flow-control event flag |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler phase that has slipped would show up as a change in `rd_value`, in mode 0, that happens one or more ticks early or late. It would also show up as a `tx_hold` falling edge that is off by the same amount. Because both outputs are compared every clock, the error is caught on the first slot boundary after it happens. A lost or misapplied held-back write shows on `tx_quanta` at the first edge with `tx_active` low. A countdown that wraps below zero raises `tx_hold` again in the cycle after it reaches zero.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int unsigned QUANTA_W  = 16;
    localparam int unsigned SLOT_LOG2 = 9;

    typedef logic [QUANTA_W-1:0] quanta_t;

    typedef struct packed {
        logic    valid;
        quanta_t data;
    } wr_req_t;

    typedef enum logic {
        VIEW_REMAINING = 1'b0,
        VIEW_TXPARAM   = 1'b1
    } view_e;

    function automatic quanta_t pick_view(view_e v, quanta_t param, quanta_t remaining);
        return (v == VIEW_TXPARAM) ? param : remaining;
    endfunction
endpackage

// File: rtl/fc_slot_prescaler.sv
module fc_slot_prescaler #(
    parameter int unsigned SLOT_LOG2 = fc_pkg::SLOT_LOG2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic wrap
);
    localparam logic [SLOT_LOG2-1:0] PRE_MAX = {SLOT_LOG2{1'b1}};

    logic [SLOT_LOG2-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            pre <= '0;
        end else if (tick) begin
            pre <= pre + 1'b1;
        end
    end

    assign wrap = run && !restart && tick && (pre == PRE_MAX);

    // R1: a fresh slot never ends in the first cycle after a restart
    a_r1_no_early_wrap: assert property (@(posedge clk) disable iff (rst)
        restart |=> !wrap);
endmodule

// File: rtl/fc_pause_counter.sv
module fc_pause_counter #(
    parameter int unsigned QW = fc_pkg::QUANTA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [QW-1:0] load_val,
    input  logic          step,
    output logic [QW-1:0] count,
    output logic          active
);
    localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step && (count != '0)) begin
            count <= count - ONE;
        end
    end

    assign active = (count != '0);

    // R1: the count moves only on a slot boundary or a load
    a_r1_moves_on_slot: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(count));
    // R5: a slot boundary takes exactly one away
    a_r5_one_down: assert property (@(posedge clk) disable iff (rst)
        (!load && step) |=> (count == $past(count) - ONE));
endmodule

// File: rtl/fc_param_reg.sv
module fc_param_reg #(
    parameter int unsigned QW = fc_pkg::QUANTA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_tx,
    input  logic          tx_active,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_data,
    output logic [QW-1:0] param
);
    typedef struct packed {
        logic          valid;
        logic [QW-1:0] data;
    } held_t;

    held_t held;
    logic  wr_ok;

    assign wr_ok = wr_en && mode_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            param <= '0;
            held  <= '0;
        end else if (wr_ok && !tx_active) begin
            param      <= wr_data;
            held.valid <= 1'b0;
        end else if (wr_ok) begin
            held.valid <= 1'b1;
            held.data  <= wr_data;
        end else if (held.valid && !tx_active) begin
            param      <= held.data;
            held.valid <= 1'b0;
        end
    end

    // R7: the value in use is frozen while a frame is being sent
    a_r7_frozen_in_tx: assert property (@(posedge clk) disable iff (rst)
        tx_active |=> $stable(param));
    // R4: with nothing to apply, a write in the remaining-count view does nothing
    a_r4_ignored_write: assert property (@(posedge clk) disable iff (rst)
        (!mode_tx && !held.valid) |=> $stable(param));
endmodule

// File: rtl/fc_event_flag.sv
module fc_event_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr_wr,
    input  logic clr_data,
    input  logic en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr_wr && clr_data) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && en;

    // R8: every acceptance leaves the flag set
    a_r8_set_on_accept: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);
    // R9: a zero written to the flag keeps it
    a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (flag && !(clr_wr && clr_data)) |=> flag);
endmodule

// File: rtl/pause_flow_timer.sv
module pause_flow_timer
    import fc_pkg::*;
#(
    parameter int unsigned QW        = QUANTA_W,
    parameter int unsigned SLOT_BITS = SLOT_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_tick,
    input  logic          pause_acc,
    input  logic [QW-1:0] pause_quanta,
    input  logic          mode_tx,
    input  logic          tx_active,
    input  logic          wr_en,
    input  logic [QW-1:0] wr_data,
    input  logic          flag_wr,
    input  logic          flag_wr_data,
    input  logic          irq_en,
    output logic          tx_hold,
    output logic [QW-1:0] rd_value,
    output logic [QW-1:0] tx_quanta,
    output logic          rfc_flag,
    output logic          irq
);
    logic          slot_wrap;
    logic          pausing;
    logic [QW-1:0] remaining;
    logic [QW-1:0] param;

    fc_slot_prescaler #(.SLOT_LOG2(SLOT_BITS)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .tick    (bit_tick),
        .run     (pausing),
        .restart (pause_acc),
        .wrap    (slot_wrap)
    );

    fc_pause_counter #(.QW(QW)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (pause_acc),
        .load_val (pause_quanta),
        .step     (slot_wrap),
        .count    (remaining),
        .active   (pausing)
    );

    fc_param_reg #(.QW(QW)) u_param (
        .clk       (clk),
        .rst       (rst),
        .mode_tx   (mode_tx),
        .tx_active (tx_active),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .param     (param)
    );

    fc_event_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .set      (pause_acc),
        .clr_wr   (flag_wr),
        .clr_data (flag_wr_data),
        .en       (irq_en),
        .flag     (rfc_flag),
        .irq      (irq)
    );

    assign tx_hold   = pausing;
    assign tx_quanta = param;
    assign rd_value  = mode_tx ? param : remaining;

    // R6: zero quanta releases the transmitter on the next cycle
    a_r6_zero_release: assert property (@(posedge clk) disable iff (rst)
        (pause_acc && (pause_quanta == '0)) |=> !tx_hold);
    // R5: nonzero quanta stops the transmitter on the next cycle
    a_r5_hold_on_load: assert property (@(posedge clk) disable iff (rst)
        (pause_acc && (pause_quanta != '0)) |=> tx_hold);
endmodule

// File: tb/test_pause_flow_timer.sv
`timescale 1ns/1ps
module test_pause_flow_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_tick = 1'b0;
    logic        pause_acc = 1'b0;
    logic [15:0] pause_quanta = '0;
    logic        mode_tx = 1'b0;
    logic        tx_active = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        flag_wr = 1'b0;
    logic        flag_wr_data = 1'b0;
    logic        irq_en = 1'b0;
    logic        tx_hold;
    logic [15:0] rd_value;
    logic [15:0] tx_quanta;
    logic        rfc_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pause_flow_timer i_pause_flow_timer (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .pause_acc(pause_acc),
        .pause_quanta(pause_quanta), .mode_tx(mode_tx), .tx_active(tx_active),
        .wr_en(wr_en), .wr_data(wr_data), .flag_wr(flag_wr),
        .flag_wr_data(flag_wr_data), .irq_en(irq_en), .tx_hold(tx_hold),
        .rd_value(rd_value), .tx_quanta(tx_quanta), .rfc_flag(rfc_flag), .irq(irq)
    );

    // behavioural reference: quanta loaded, ticks elapsed since acceptance
    int m_q, m_el, m_param, m_pv;
    bit m_pend, m_flag;

    function automatic int m_rem();
        int r;
        r = m_q - (m_el / 512);
        return (r < 0) ? 0 : r;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_q = 0; m_el = 0; m_param = 0; m_pv = 0; m_pend = 0; m_flag = 0;
        end else begin
            if (pause_acc) begin
                m_q = pause_quanta; m_el = 0;
            end else if (bit_tick && m_rem() > 0) begin
                m_el = m_el + 1;
            end
            if (wr_en && mode_tx && !tx_active) begin
                m_param = wr_data; m_pend = 0;
            end else if (wr_en && mode_tx) begin
                m_pend = 1; m_pv = wr_data;
            end else if (m_pend && !tx_active) begin
                m_param = m_pv; m_pend = 0;
            end
            if (pause_acc) m_flag = 1;
            else if (flag_wr && flag_wr_data) m_flag = 0;
        end
    end

    // per-cycle comparison, 1 ns after each edge
    always @(posedge clk) begin
        #1;
        if (!done) begin
            chk(mode_tx ? "R2 rd_value" : "R3 rd_value", rd_value,
                mode_tx ? m_param : m_rem());
            chk("R2 tx_quanta", tx_quanta, m_param);
            chk("R5 tx_hold", tx_hold, (m_rem() != 0) ? 1 : 0);
            chk("R8 rfc_flag", rfc_flag, m_flag);
            chk("R8 irq", irq, (m_flag && irq_en) ? 1 : 0);
        end
    end

    task automatic nclk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        nclk(3);
        rst = 1'b0;
        nclk(1);
        chk("R10 reset rd_value", rd_value, 0);
        chk("R10 reset tx_hold", tx_hold, 0);
        chk("R10 reset rfc_flag", rfc_flag, 0);

        mode_tx = 1; wr_en = 1; wr_data = 16'd5;
        nclk(1); wr_en = 0;
        chk("R2 write visible", rd_value, 5);
        chk("R2 tx_quanta", tx_quanta, 5);

        mode_tx = 0; wr_en = 1; wr_data = 16'h1234;
        nclk(1); wr_en = 0; mode_tx = 1;
        nclk(1);
        chk("R4 write ignored", rd_value, 5);

        tx_active = 1; wr_en = 1; wr_data = 16'd9;
        nclk(1); wr_en = 0;
        chk("R7 deferred", rd_value, 5);
        nclk(3);
        chk("R7 still deferred", tx_quanta, 5);
        tx_active = 0;
        nclk(1);
        chk("R7 applied", rd_value, 9);

        mode_tx = 0; bit_tick = 1; irq_en = 0; pause_acc = 1; pause_quanta = 16'd3;
        nclk(1); pause_acc = 0;
        chk("R5 hold on", tx_hold, 1);
        chk("R3 loaded", rd_value, 3);
        chk("R8 flag set", rfc_flag, 1);
        chk("R8 irq masked", irq, 0);
        nclk(511);
        chk("R1 before boundary", rd_value, 3);
        nclk(1);
        chk("R1 at boundary", rd_value, 2);
        irq_en = 1;
        #1;
        chk("R8 irq enabled", irq, 1);
        nclk(1024);
        chk("R5 end count", rd_value, 0);
        chk("R5 hold off", tx_hold, 0);
        nclk(600);
        chk("R5 no wrap", rd_value, 0);

        flag_wr = 1; flag_wr_data = 0;
        nclk(1);
        chk("R9 zero write", rfc_flag, 1);
        flag_wr_data = 1;
        nclk(1); flag_wr = 0;
        chk("R9 clear", rfc_flag, 0);

        pause_acc = 1; pause_quanta = 16'd100; flag_wr = 1; flag_wr_data = 1;
        nclk(1); pause_acc = 0; flag_wr = 0;
        chk("R9 set wins", rfc_flag, 1);
        nclk(20);
        pause_acc = 1; pause_quanta = 16'd0;
        nclk(1); pause_acc = 0;
        chk("R6 release", tx_hold, 0);
        chk("R6 count", rd_value, 0);

        mode_tx = 1; pause_acc = 1; pause_quanta = 16'd7;
        nclk(1); pause_acc = 0;
        chk("R2 param view", rd_value, 9);
        mode_tx = 0;
        #1;
        chk("R3 loaded in tx view", rd_value, 7);

        nclk(1);
        rst = 1;
        nclk(1); rst = 0;
        nclk(1);
        chk("R10 hold cleared", tx_hold, 0);
        chk("R10 count cleared", rd_value, 0);
        chk("R10 flag cleared", rfc_flag, 0);
        mode_tx = 1;
        #1;
        chk("R10 param cleared", rd_value, 0);

        for (int c = 0; c < 30000; c++) begin
            @(negedge clk);
            bit_tick     = ($urandom_range(0, 3) != 0);
            pause_acc    = ($urandom_range(0, 999) == 0);
            pause_quanta = 16'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) mode_tx = ~mode_tx;
            if ($urandom_range(0, 19) == 0) tx_active = ~tx_active;
            wr_en        = ($urandom_range(0, 49) == 0);
            wr_data      = 16'($urandom);
            flag_wr      = ($urandom_range(0, 199) == 0);
            flag_wr_data = 1'($urandom_range(0, 1));
            irq_en       = 1'($urandom_range(0, 1));
            rst          = ($urandom_range(0, 9999) == 0);
        end
        @(negedge clk);
        rst = 0; pause_acc = 0; wr_en = 0; flag_wr = 0;
        nclk(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule